// File: doc/BRIEF.md
# Two-Wire Control Bus Snooping Router

The block watches an upstream two-wire control bus (a clock line and a data line) and decides where that bus is steered. There are three destinations: an external configuration PROM, a display-data (DDC) port, and the chip's own register slave. After reset the bus is passed to the PROM and the block only listens. It claims the bus for the internal registers when an address byte carrying its own device address goes by. While the internal registers own the bus, a command from the register side can order the next destination. That order is carried out at the next STOP condition, so a transfer is never cut in half.

The two bus lines enter through a parameterised synchronizer chain clocked by a system clock that runs at least 16 times the bus bit rate. START (data falling while the clock line is high) and STOP (data rising while the clock line is high) are detected from the synchronized samples. Only the first byte after a START or repeated START is treated as an address. When the bus is routed to the DDC port, the block waits for a START followed by a STOP and then hands the bus back to the internal registers. The downstream paths are meant for different speeds: up to 1 MHz for the register slave, 400 kHz for the PROM and 100 kHz for the DDC. The bus master is expected to pace itself to the destination it is using.

Top module: `tw_snoop_router`

## Requirements
- R1: While reset is asserted and on the first clock after it, the route is the PROM: `prom_en_o`=1, `reg_sel_o`=0, `ddc_en_o`=0.
- R2: A data-line change while the clock line is low is a data bit, not a START or STOP, and causes no route change.
- R3: The device address byte is 0x72 when `addr_sel_i`=0 and 0x70 when `addr_sel_i`=1. This means bits [7:1] = {011100, not `addr_sel_i`}, with bit 7 sent first. Bit 0 (read/write) is ignored. A matching address byte seen while routed to the PROM switches the route to the internal registers and drops `prom_en_o`.
- R4: An address byte that does not match leaves the current route unchanged.
- R5: The redirect command (`redir_wr_i` pulse, `redir_tgt_i`: 0 = PROM, 1 = DDC) is accepted only while routed to the internal registers. A pulse on any other route has no effect.
- R6: An accepted redirect takes effect at the next STOP. Until then the route stays on the internal registers.
- R7: While routed to DDC, a STOP that has no START before it since the DDC route began keeps the route on DDC. A STOP after a START returns the route to the internal registers.
- R8: Exactly one of `prom_en_o`, `reg_sel_o`, `ddc_en_o` is high at every cycle outside reset.
- R9: Only the first byte after a START or repeated START is compared with the device address. A later data byte with the same value has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled upstream bus clock line |
| sda_i | input | 1 | Sampled upstream bus data line |
| addr_sel_i | input | 1 | Address-select pin level |
| redir_wr_i | input | 1 | One-cycle pulse that writes the redirect target |
| redir_tgt_i | input | 1 | Redirect target: 0 = PROM, 1 = DDC |
| prom_en_o | output | 1 | Enables the PROM downstream path |
| ddc_en_o | output | 1 | Enables the DDC downstream path |
| reg_sel_o | output | 1 | Selects the internal register slave |

## Verification
The assertions check the invariants on every cycle: one route only, the register route is left only on a STOP, the DDC route is left only on a STOP, the PROM route is left only after an address hit, and the DDC route can only be entered from the register route. Some behaviour depends on the bus history and only the scenarios can show it. This covers whether a byte is an address or a data byte, whether the two address-select encodings and the ignored read/write bit are honoured, whether a redirect pulse given on the PROM route was really dropped, and whether a STOP with no START before it keeps the DDC route. A behavioural model driven from the same stimulus is compared with the three enables on every clock.

// File: rtl/tw_snoop_pkg.sv
package tw_snoop_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [5:0]  DEV_PREFIX = 6'b011100;

    typedef enum logic [1:0] {
        RT_PROM = 2'd0,
        RT_REG  = 2'd1,
        RT_DDC  = 2'd2
    } route_e;

    typedef enum logic {
        TGT_PROM = 1'b0,
        TGT_DDC  = 1'b1
    } tgt_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic sda;
    } bus_evt_t;

    function automatic logic [6:0] dev_addr(input logic sel);
        return {DEV_PREFIX, ~sel};
    endfunction

endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync
    import tw_snoop_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [STAGES-1:0] scl_s;
    logic [STAGES-1:0] sda_s;
    logic              scl_p;
    logic              sda_p;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_s[0] <= 1'b1;
                    sda_s[0] <= 1'b1;
                end else begin
                    scl_s[0] <= scl_i;
                    sda_s[0] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_s[k] <= 1'b1;
                    sda_s[k] <= 1'b1;
                end else begin
                    scl_s[k] <= scl_s[k-1];
                    sda_s[k] <= sda_s[k-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s[STAGES-1];
            sda_p <= sda_s[STAGES-1];
        end
    end

    always_comb begin
        evt_o.sda      = sda_s[STAGES-1];
        evt_o.scl_rise = scl_s[STAGES-1] & ~scl_p;
        evt_o.start    = scl_s[STAGES-1] & scl_p & sda_p & ~sda_s[STAGES-1];
        evt_o.stop     = scl_s[STAGES-1] & scl_p & ~sda_p & sda_s[STAGES-1];
    end

endmodule

// File: rtl/tw_addr_snoop.sv
module tw_addr_snoop
    import tw_snoop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt_i,
    input  logic     addr_sel_i,
    output logic     addr_hit_o
);

    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              in_addr;
    logic [BYTE_W-1:0] full_byte;
    logic              last_edge;

    assign full_byte  = {shreg, evt_i.sda};
    assign last_edge  = in_addr & evt_i.scl_rise & (bit_cnt == LAST_BIT);
    assign addr_hit_o = last_edge & (full_byte[BYTE_W-1:1] == dev_addr(addr_sel_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            in_addr <= 1'b0;
        end else if (evt_i.start) begin
            bit_cnt <= '0;
            in_addr <= 1'b1;
        end else if (evt_i.stop) begin
            in_addr <= 1'b0;
        end else if (in_addr && evt_i.scl_rise) begin
            shreg   <= full_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) in_addr <= 1'b0;
        end
    end

endmodule

// File: rtl/tw_route_fsm.sv
module tw_route_fsm
    import tw_snoop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt_i,
    input  logic     addr_hit_i,
    input  logic     redir_wr_i,
    input  logic     redir_tgt_i,
    output route_e   route_o
);

    route_e route;
    tgt_e   pend_tgt;
    logic   pend_vld;
    logic   ddc_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            route    <= RT_PROM;
            pend_tgt <= TGT_PROM;
            pend_vld <= 1'b0;
            ddc_seen <= 1'b0;
        end else begin
            unique case (route)
                RT_PROM: if (addr_hit_i) route <= RT_REG;
                RT_REG:  if (evt_i.stop && pend_vld)
                             route <= (pend_tgt == TGT_DDC) ? RT_DDC : RT_PROM;
                RT_DDC:  if (evt_i.stop && ddc_seen) route <= RT_REG;
                default: route <= RT_PROM;
            endcase
            if (route == RT_REG && redir_wr_i) begin
                pend_vld <= 1'b1;
                pend_tgt <= tgt_e'(redir_tgt_i);
            end else if (evt_i.stop) begin
                pend_vld <= 1'b0;
            end
            ddc_seen <= (route == RT_DDC) && (ddc_seen || evt_i.start);
        end
    end

    assign route_o = route;

endmodule

// File: rtl/tw_snoop_router.sv
module tw_snoop_router
    import tw_snoop_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel_i,
    input  logic redir_wr_i,
    input  logic redir_tgt_i,
    output logic prom_en_o,
    output logic ddc_en_o,
    output logic reg_sel_o
);

    bus_evt_t bus_evt;
    logic     addr_hit;
    logic     stop_evt;
    route_e   route;

    tw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (bus_evt)
    );

    tw_addr_snoop u_addr (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (bus_evt),
        .addr_sel_i (addr_sel_i),
        .addr_hit_o (addr_hit)
    );

    tw_route_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (bus_evt),
        .addr_hit_i  (addr_hit),
        .redir_wr_i  (redir_wr_i),
        .redir_tgt_i (redir_tgt_i),
        .route_o     (route)
    );

    assign stop_evt  = bus_evt.stop;
    assign prom_en_o = (route == RT_PROM);
    assign reg_sel_o = (route == RT_REG);
    assign ddc_en_o  = (route == RT_DDC);

endmodule

// File: rtl/tw_snoop_router_chk.sv
module tw_snoop_router_chk (
    input logic clk,
    input logic rst,
    input logic prom_en_o,
    input logic ddc_en_o,
    input logic reg_sel_o,
    input logic stop_evt,
    input logic addr_hit
);

    AST_RESET_TO_PROM: assert property (@(posedge clk)
        rst |=> (prom_en_o && !reg_sel_o && !ddc_en_o)); // R1

    AST_PROM_HIT_CLAIMS: assert property (@(posedge clk) disable iff (rst)
        (prom_en_o && addr_hit) |=> reg_sel_o); // R3

    AST_PROM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (prom_en_o && !addr_hit) |=> prom_en_o); // R4

    AST_DDC_FROM_REG: assert property (@(posedge clk) disable iff (rst)
        $rose(ddc_en_o) |-> $past(reg_sel_o)); // R5

    AST_REG_LEAVES_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        (reg_sel_o && !stop_evt) |=> reg_sel_o); // R6

    AST_DDC_LEAVES_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        (ddc_en_o && !stop_evt) |=> ddc_en_o); // R7

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        $countones({prom_en_o, reg_sel_o, ddc_en_o}) == 1); // R8

endmodule

bind tw_snoop_router tw_snoop_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .prom_en_o (prom_en_o),
    .ddc_en_o  (ddc_en_o),
    .reg_sel_o (reg_sel_o),
    .stop_evt  (stop_evt),
    .addr_hit  (addr_hit)
);

// File: tb/tb_tw_snoop_router.sv
`timescale 1ns/1ps
module tb_tw_snoop_router;

    localparam int SYNC = 2;
    localparam int Q    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic addr_sel = 1'b1;
    logic redir_wr = 1'b0, redir_tgt = 1'b0;
    logic prom_en, ddc_en, reg_sel;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tw_snoop_router #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst), .scl_i(scl_in), .sda_i(sda_in),
        .addr_sel_i(addr_sel), .redir_wr_i(redir_wr), .redir_tgt_i(redir_tgt),
        .prom_en_o(prom_en), .ddc_en_o(ddc_en), .reg_sel_o(reg_sel)
    );

    // behavioural reference: 0 = PROM, 1 = registers, 2 = DDC
    bit sq[$], dq[$];
    bit ps, pd;
    int m_route, m_cnt, m_pend_tgt;
    bit m_in_addr, m_pend, m_seen;
    bit [7:0] m_sh;

    always @(posedge clk) begin
        if (rst) begin
            sq = {}; dq = {};
            for (int i = 0; i < SYNC; i++) begin sq.push_back(1'b1); dq.push_back(1'b1); end
            ps = 1; pd = 1; m_route = 0; m_cnt = 0; m_in_addr = 0;
            m_pend = 0; m_pend_tgt = 0; m_seen = 0; m_sh = 0;
        end else begin
            bit cs, cd, rise, st, sp, hit, nseen;
            int nroute;
            cs = sq[SYNC-1]; cd = dq[SYNC-1];
            sq.push_front(scl_in); void'(sq.pop_back());
            dq.push_front(sda_in); void'(dq.pop_back());
            rise = cs && !ps;
            st = cs && ps && pd && !cd;
            sp = cs && ps && !pd && cd;
            hit = 0;
            if (st) begin m_in_addr = 1; m_cnt = 0; end
            else if (sp) m_in_addr = 0;
            else if (rise && m_in_addr) begin
                m_sh = {m_sh[6:0], cd};
                m_cnt++;
                if (m_cnt == 8) begin
                    m_in_addr = 0;
                    hit = (m_sh[7:1] == {6'b011100, ~addr_sel});
                end
            end
            nroute = m_route;
            if (m_route == 0 && hit) nroute = 1;
            if (m_route == 1 && sp && m_pend) nroute = (m_pend_tgt == 1) ? 2 : 0;
            if (m_route == 2 && sp && m_seen) nroute = 1;
            if (m_route == 1 && redir_wr) begin m_pend = 1; m_pend_tgt = redir_tgt; end
            else if (sp) m_pend = 0;
            nseen = (m_route == 2) && (m_seen || st);
            m_seen = nseen;
            m_route = nroute;
            ps = cs; pd = cd;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if ({prom_en, reg_sel, ddc_en} != {m_route == 0, m_route == 1, m_route == 2}) begin
                bad++;
                $display("FAIL R8 per-cycle route: got %b exp %b", {prom_en, reg_sel, ddc_en},
                         {m_route == 0, m_route == 1, m_route == 2});
            end
        end
    end

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    // route codes as {prom, reg, ddc}
    localparam logic [2:0] P = 3'b100, G = 3'b010, D = 3'b001;

    task automatic bus(input logic s, input logic d);
        @(negedge clk); scl_in = s; sda_in = d;
        repeat (Q - 1) @(negedge clk);
    endtask

    task automatic do_start(); bus(0, 1); bus(1, 1); bus(1, 0); bus(0, 0); endtask
    task automatic do_stop();  bus(0, 0); bus(1, 0); bus(1, 1); endtask
    task automatic do_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin bus(0, b[i]); bus(1, b[i]); bus(0, b[i]); end
        bus(0, 1); bus(1, 1); bus(0, 1);
    endtask
    task automatic pulse_redir(input logic t);
        @(negedge clk); redir_wr = 1; redir_tgt = t;
        @(negedge clk); redir_wr = 0;
    endtask
    task automatic settle(); repeat (6) @(negedge clk); endtask
    function automatic logic [2:0] now(); return {prom_en, reg_sel, ddc_en}; endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset route", now(), P);

        do_start(); do_byte(8'h50); do_stop(); settle();
        check("R4 foreign address keeps PROM", now(), P);

        do_start(); do_byte(8'h70); settle();
        check("R3 address 0x70 claims bus", now(), G);

        pulse_redir(1'b1);
        do_byte(8'hA5);
        check("R6 redirect waits for STOP", now(), G);
        bus(0, 0); bus(0, 1); settle();
        check("R2 SDA toggle with SCL low", now(), G);
        do_stop(); settle();
        check("R6 redirect to DDC at STOP", now(), D);

        bus(0, 1); do_stop(); settle();
        check("R7 STOP without START keeps DDC", now(), D);
        do_start(); do_byte(8'h3C); settle();
        check("R7 mid DDC transfer", now(), D);
        do_stop(); settle();
        check("R7 START then STOP returns to regs", now(), G);

        pulse_redir(1'b0); do_stop(); settle();
        check("R5 redirect to PROM", now(), P);
        pulse_redir(1'b1);
        do_start(); do_byte(8'h71); do_stop(); settle();
        check("R5 redirect on PROM route ignored", now(), G);

        pulse_redir(1'b0); do_stop(); settle();
        addr_sel = 1'b0;
        do_start(); do_byte(8'h70); do_stop(); settle();
        check("R3 0x70 foreign when select low", now(), P);
        do_start(); do_byte(8'h73); settle();
        check("R3 0x73 read bit ignored", now(), G);

        pulse_redir(1'b0); do_stop(); settle();
        do_start(); do_byte(8'h10); do_byte(8'h72); settle();
        check("R9 data byte equal to address", now(), P);
        do_start(); do_byte(8'h72); settle();
        check("R9 repeated START address", now(), G);
        do_stop(); settle();

        @(negedge clk); rst = 1;
        @(negedge clk);
        check("R1 reset from register route", now(), P);
        @(negedge clk); rst = 0;
        settle();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule